// File: doc/BRIEF.md
# Snoop-Push Data Tenure Tracker

This block sits on the system side of a shared bus and follows the data-only transfers that one snooping processor makes. These are the transfers where the processor pushes modified data after it reports a snoop hit. Every clock cycle it samples three inputs: the processor's snoop-hit indication, the shared address-retry indication and the processor's data-ready request. A hit that is not cancelled by a retry in the same cycle is queued, together with a 4-bit transaction tag taken from the address phase.

Data-ready requests are matched strictly against the oldest queued hit. Each accepted request is reported for one cycle with the tag of the transaction it serves. A request that arrives while no valid hit is outstanding is discarded and counted in a saturating counter. A hit that finds the queue full is dropped and raises a sticky error flag.

Top module: `snoop_push_tracker`

## Requirements
- R1: A hit sampled in the same cycle as a retry creates no queue entry. A later data-ready request with nothing else outstanding is therefore treated as spurious.
- R2: A data-ready request with no valid hit outstanding, and no valid hit in the same cycle, produces no acceptance and increments the spurious counter by one.
- R3: A data-ready request sampled in the same cycle as a retried hit is credited to the oldest queued valid hit, and the matched tag is that older hit's tag.
- R4: Queued hits are served in the order they were accepted. Successive acceptances present the tags in arrival order.
- R5: Several hits may be queued before any data-ready request arrives, and a data-ready request may come several cycles after its hit.
- R6: A retry affects only the hit in its own cycle. A hit three cycles after a retry is queued normally.
- R7: A data-ready request accepted in cycle N makes accept_o high in cycle N+1, for that cycle only, with accept_tag_o holding the matched tag. The matched entry is removed.
- R8: A data-ready request in the same cycle as a valid hit, while the queue is empty, is accepted with that hit's tag, and the hit is not queued.
- R9: A valid hit arriving with the queue holding 4 entries and no data-ready request is dropped and sets overflow_o, which stays high until reset. The existing entries are kept.
- R10: With the queue full, a valid hit and a data-ready request in the same cycle pop the oldest entry and push the new one, without raising overflow_o.
- R11: The 8-bit spurious counter saturates at 255.
- R12: A synchronous active-low reset empties the queue and clears accept_o, overflow_o and the spurious counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_i | input | 1 | Snoop hit reported by the processor |
| retry_i | input | 1 | Shared address retry, cancels a same-cycle hit |
| tag_i | input | 4 | Transaction tag of the current address phase |
| drdy_i | input | 1 | Data-ready request from the processor |
| accept_o | output | 1 | One-cycle pulse for an accepted data-ready request |
| accept_tag_o | output | 4 | Tag of the transaction the accepted request serves |
| overflow_o | output | 1 | Sticky queue overflow error |
| spurious_cnt_o | output | 8 | Saturating count of discarded data-ready requests |

## Verification
The hardest situation to reach is a data-ready request that coincides with a new hit and a retry while an older valid hit is still queued. It has to be credited to the older hit. The queue depth then has to be shown by the lack of an acceptance for a following request. The bench builds this state by queuing one hit, then driving hit, retry and data-ready together in a single cycle. It then issues one more data-ready request, which must come out as spurious. The full-queue push-and-pop case is reached in a similar way: the queue is filled to depth first, and the bench then drains it and checks the tag order.

// File: rtl/spt_pkg.sv
package spt_pkg;

    // How a sampled data-ready request is resolved in one cycle
    typedef enum logic [1:0] {
        DR_NONE   = 2'd0,
        DR_QUEUED = 2'd1,
        DR_BYPASS = 2'd2,
        DR_SPUR   = 2'd3
    } drdy_kind_e;

    function automatic drdy_kind_e classify_drdy(
        input logic drdy,
        input logic q_empty,
        input logic hit_ok
    );
        drdy_kind_e k;
        if (!drdy)        k = DR_NONE;
        else if (!q_empty) k = DR_QUEUED;
        else if (hit_ok)  k = DR_BYPASS;
        else              k = DR_SPUR;
        return k;
    endfunction

endpackage

// File: rtl/spt_tag_queue.sv
module spt_tag_queue #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [TAG_W-1:0] push_tag,
    output logic [TAG_W-1:0] head_tag,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
    } q_state_t;

    q_state_t st_d, st_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_tag;
            st_d.wr           = bump(st_q.wr);
        end
        if (pop) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_tag = st_q.mem[st_q.rd];
    assign empty    = (st_q.cnt == '0);
    assign full     = (st_q.cnt == FULL_CNT);

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop) else $error("push into full queue"); // R9
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty) else $error("pop from empty queue"); // R7
    AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(st_q.cnt)) else $error("occupancy moved"); // R10

endmodule

// File: rtl/spt_sat_counter.sv
module spt_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != TOP)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign value = cnt_q;

    AST_SAT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP) |=> (cnt_q == TOP)) else $error("counter wrapped"); // R11
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + W'(1))) else $error("bad step"); // R2

endmodule

// File: rtl/snoop_push_tracker.sv
module snoop_push_tracker #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             retry_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             drdy_i,
    output logic             accept_o,
    output logic [TAG_W-1:0] accept_tag_o,
    output logic             overflow_o,
    output logic [CNT_W-1:0] spurious_cnt_o
);
    import spt_pkg::*;

    typedef struct packed {
        logic             accept;
        logic [TAG_W-1:0] tag;
        logic             ovf;
    } out_state_t;

    out_state_t st_d, st_q;

    logic             hit_ok;
    logic             q_push, q_pop, q_empty, q_full;
    logic [TAG_W-1:0] q_head;
    logic             spur_inc;
    drdy_kind_e       kind;

    spt_tag_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) queue_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .pop      (q_pop),
        .push_tag (tag_i),
        .head_tag (q_head),
        .empty    (q_empty),
        .full     (q_full)
    );

    spt_sat_counter #(.W(CNT_W)) spur_ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (spur_inc),
        .value (spurious_cnt_o)
    );

    always_comb begin
        hit_ok   = hit_i && !retry_i;
        kind     = classify_drdy(drdy_i, q_empty, hit_ok);
        st_d     = st_q;
        st_d.accept = 1'b0;
        q_pop    = 1'b0;
        q_push   = 1'b0;
        spur_inc = 1'b0;
        case (kind)
            DR_QUEUED: begin
                st_d.accept = 1'b1;
                st_d.tag    = q_head;
                q_pop       = 1'b1;
                q_push      = hit_ok;
            end
            DR_BYPASS: begin
                st_d.accept = 1'b1;
                st_d.tag    = tag_i;
            end
            DR_SPUR: begin
                spur_inc = 1'b1;
            end
            default: begin
                if (hit_ok) begin
                    if (q_full) st_d.ovf = 1'b1;
                    else        q_push   = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept_o     = st_q.accept;
    assign accept_tag_o = st_q.tag;
    assign overflow_o   = st_q.ovf;

    AST_RETRY_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_i && !q_pop) |-> !q_push) else $error("retried hit queued"); // R1
    AST_ACCEPT_FROM_DRDY: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(drdy_i)) else $error("accept without request"); // R7
    AST_SPUR_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        spur_inc |=> !accept_o) else $error("spurious request accepted"); // R2
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o) else $error("overflow flag dropped"); // R9

endmodule

// File: tb/snoop_push_tracker_tb.sv
module snoop_push_tracker_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       hit_i, retry_i, drdy_i;
    logic [3:0] tag_i;
    logic       accept_o;
    logic [3:0] accept_tag_o;
    logic       overflow_o;
    logic [7:0] spurious_cnt_o;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    snoop_push_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .retry_i(retry_i),
        .tag_i(tag_i), .drdy_i(drdy_i), .accept_o(accept_o),
        .accept_tag_o(accept_tag_o), .overflow_o(overflow_o),
        .spurious_cnt_o(spurious_cnt_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one cycle at a falling edge; returns at the next falling edge
    task automatic step(input logic h, input logic r, input logic d, input logic [3:0] t);
        hit_i = h; retry_i = r; drdy_i = d; tag_i = t;
        @(posedge clk);
        @(negedge clk);
        hit_i = 0; retry_i = 0; drdy_i = 0; tag_i = 0;
    endtask

    task automatic expect_accept(input string req, input int tag);
        check({req, " accept"}, accept_o, 1);
        check({req, " tag"}, accept_tag_o, tag);
    endtask

    task automatic expect_spur(input string req);
        exp_cnt = (exp_cnt < 255) ? exp_cnt + 1 : 255;
        check({req, " no accept"}, accept_o, 0);
        check({req, " count"}, spurious_cnt_o, exp_cnt);
    endtask

    task automatic do_reset();
        rst_n = 0;
        hit_i = 0; retry_i = 0; drdy_i = 0; tag_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        exp_cnt = 0;
        check("R12 accept", accept_o, 0);
        check("R12 overflow", overflow_o, 0);
        check("R12 count", spurious_cnt_o, 0);
    endtask

    task automatic t_retried_hit();
        step(1, 1, 0, 4'd5);
        step(0, 0, 1, 4'd0);
        expect_spur("R1");
        step(0, 0, 1, 4'd0);
        expect_spur("R2");
    endtask

    task automatic t_pipeline();
        step(1, 0, 0, 4'd1);
        step(1, 0, 0, 4'd2);
        step(1, 0, 0, 4'd3);
        step(0, 0, 0, 4'd0);
        step(0, 0, 0, 4'd0);
        step(0, 0, 1, 4'd0);
        expect_accept("R5", 1);
        step(0, 0, 0, 4'd0);
        check("R7 pulse ends", accept_o, 0);
        step(0, 0, 1, 4'd0);
        expect_accept("R4", 2);
        step(0, 0, 1, 4'd0);
        expect_accept("R4", 3);
        step(0, 0, 1, 4'd0);
        expect_spur("R7 popped");
    endtask

    task automatic t_retry_with_drdy();
        step(1, 0, 0, 4'd7);
        step(1, 1, 1, 4'd8);
        expect_accept("R3", 7);
        step(0, 0, 1, 4'd0);
        expect_spur("R3 cancelled hit");
    endtask

    task automatic t_after_retry();
        step(1, 1, 0, 4'd9);
        step(0, 0, 0, 4'd0);
        step(0, 0, 0, 4'd0);
        step(1, 0, 0, 4'd10);
        step(0, 0, 1, 4'd0);
        expect_accept("R6", 10);
    endtask

    task automatic t_bypass();
        step(1, 0, 1, 4'd11);
        expect_accept("R8", 11);
        step(0, 0, 1, 4'd0);
        expect_spur("R8 not queued");
    endtask

    task automatic t_full_pushpop();
        for (int i = 1; i <= 4; i++) step(1, 0, 0, 4'(i));
        step(1, 0, 1, 4'd5);
        expect_accept("R10", 1);
        check("R10 overflow", overflow_o, 0);
        for (int i = 2; i <= 5; i++) begin
            step(0, 0, 1, 4'd0);
            expect_accept("R10 order", i);
        end
        step(0, 0, 1, 4'd0);
        expect_spur("R10 drained");
    endtask

    task automatic t_overflow();
        for (int i = 6; i <= 9; i++) step(1, 0, 0, 4'(i));
        step(1, 0, 0, 4'd12);
        check("R9 overflow", overflow_o, 1);
        for (int i = 6; i <= 9; i++) begin
            step(0, 0, 1, 4'd0);
            expect_accept("R9 kept", i);
        end
        step(0, 0, 1, 4'd0);
        expect_spur("R9 dropped");
        check("R9 sticky", overflow_o, 1);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 260; i++) step(0, 0, 1, 4'd0);
        check("R11 saturate", spurious_cnt_o, 255);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_retried_hit();
        t_pipeline();
        t_retry_with_drdy();
        t_after_retry();
        t_bypass();
        t_full_pushpop();
        t_overflow();
        t_saturate();
        do_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule